// File: doc/BRIEF.md
# DMA Channel Request Sequencer

This block sequences one DMA channel. It watches a request line from a peripheral, raises an acknowledge and issues one atomic transfer at a time to a transfer engine through a start/done handshake. After each completed atomic transfer it lowers the remaining transfer count by one. When the count reaches zero it stops issuing transfers and reports terminal count. Terminal count is reported as a one-cycle interrupt pulse, which can be turned off, and as a sticky flag.

Three static control inputs set the channel's behaviour. One selects the request semantics: demand or handshake. One selects the atomic size: one unit or a burst of four. One enables the interrupt. All three are zero after reset. The request line comes from another domain, so it passes through a two-flop synchronizer before the state machine sees it. The acknowledge is driven from a register.

Top module: `dma_chan_seq`

## Requirements
- R1: During and right after synchronous reset, `dack`, `xfer_start`, `tc_irq`, `tc_flag` and `cur_count` are all 0.
- R2: A transfer starts when the channel is idle and enabled, the synchronized request is high and the count is nonzero. On that edge `xfer_start` pulses for one cycle and `dack` rises. No further `xfer_start` is issued until `xfer_done` ends the transfer.
- R3: In handshake mode (`mode_hs`=1), `dack` stays high after `xfer_done` for as long as the synchronized request is high. It falls on the edge where the synchronized request is seen low. A new transfer then needs the request to be seen high again.
- R4: In demand mode (`mode_hs`=0), `dack` falls on the edge that takes `xfer_done`. If the synchronized request is still high, the following edge starts the next transfer, so `dack` is low for exactly one cycle.
- R5: While `xfer_start` is high, `xfer_len` reads 1 when `burst4`=0 and 4 when `burst4`=1.
- R6: `cur_count` loads `init_count` on the first edge at which `chan_en` is high after being low. It decreases by one on each `xfer_done` taken while a transfer is busy. A `xfer_done` at any other time is ignored.
- R7: When `irq_en`=1, `tc_irq` is high for exactly one cycle, right after the edge on which `cur_count` goes from 1 to 0. When `irq_en`=0, `tc_irq` stays 0.
- R8: `tc_flag` is set when `cur_count` goes from 1 to 0, whatever the value of `irq_en`. It holds until `tc_clr` is seen, and it clears on that edge unless it is being set on the same edge, in which case setting wins.
- R9: When `chan_en` is low at an edge, the channel goes idle: `dack` is 0 after that edge, no transfer starts, and `cur_count` keeps its value.
- R10: A rise of `dreq` set up before edge E1 is seen by the state machine at E3. From idle, `dack` is therefore first high after the third rising edge.
- R11: While `cur_count` is 0 no transfer starts and `dack` stays low, whatever `dreq` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_en | input | 1 | Channel enable; a rising level loads the count |
| mode_hs | input | 1 | 1: handshake request semantics, 0: demand |
| burst4 | input | 1 | 1: four-unit atomic transfer, 0: single unit |
| irq_en | input | 1 | Enables the terminal-count interrupt pulse |
| init_count | input | CNT_W | Number of atomic transfers to perform |
| dreq | input | 1 | Request from the peripheral, asynchronous |
| dack | output | 1 | Acknowledge to the peripheral, registered |
| xfer_start | output | 1 | One-cycle start pulse to the transfer engine |
| xfer_len | output | 3 | Beats in the atomic transfer being started |
| xfer_done | input | 1 | One-cycle pulse from the engine when all beats are done |
| cur_count | output | CNT_W | Remaining atomic transfers |
| tc_irq | output | 1 | Terminal-count interrupt pulse |
| tc_flag | output | 1 | Sticky terminal-count status |
| tc_clr | input | 1 | Clears the sticky status |

## Verification
The hardest case to reach is the handshake hold. The request has to stay high through the whole transfer, then fall, and the acknowledge must be seen to follow the request only after the synchronizer delay. The stimulus builds this case directly, holding the request over a full transfer before releasing it. The randomized phases add rarer overlaps on top of that: a disable during a busy transfer, a done pulse from the engine arriving while idle or holding, and a clear on the same edge as terminal count.

// File: rtl/dma_seq_pkg.sv
// Package: shared state type and burst-length helper for the DMA channel
// sequencer. Assumes atomic transfers are either one unit or four units.
package dma_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BUSY = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_t;

    localparam int UNIT_BEATS  = 1;
    localparam int BURST_BEATS = 4;

    // Beats per atomic transfer for a given size select.
    function automatic int beats_for(input logic four);
        return four ? BURST_BEATS : UNIT_BEATS;
    endfunction

endpackage

// File: rtl/dma_req_sync.sv
// Module: multi-flop synchronizer for the incoming request line.
// Assumes STAGES >= 2 and that the input is a level that lasts several
// cycles; narrow glitches may be missed.
module dma_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw request through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/dma_tc_counter.sv
// Module: remaining-transfer counter with terminal-count pulse and sticky flag.
// Assumes load and dec are never requested together (load happens only
// while the sequencer is idle).
module dma_tc_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] init,
    input  logic             dec,
    input  logic             irq_en,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             is_zero,
    output logic             tc_irq,
    output logic             tc_flag
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic take;
    logic reach_zero;

    assign take       = dec && (count != '0);
    assign reach_zero = take && (count == ONE);
    assign is_zero    = (count == '0);

    // Load or step down the remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= init;
        end else if (take) begin
            count <= count - ONE;
        end
    end

    // One-cycle interrupt pulse and sticky status on reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_irq  <= 1'b0;
            tc_flag <= 1'b0;
        end else begin
            tc_irq <= reach_zero && irq_en;
            if (reach_zero) begin
                tc_flag <= 1'b1;
            end else if (clr) begin
                tc_flag <= 1'b0;
            end
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !load) |=> (count == $past(count) - ONE)); // R6
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_irq |=> !tc_irq); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !tc_irq); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_flag && !clr) |=> tc_flag); // R8

endmodule

// File: rtl/dma_seq_fsm.sv
// Module: request/acknowledge state machine for one channel.
// Assumes req_s is already synchronized and that the transfer engine
// returns exactly one done pulse per start pulse.
module dma_seq_fsm
    import dma_seq_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             req_s,
    input  logic             cnt_zero,
    input  logic             mode_hs,
    input  logic             burst4,
    input  logic             xfer_done,
    output logic             dack,
    output logic             xfer_start,
    output logic [LEN_W-1:0] xfer_len,
    output logic             beat_end
);

    seq_state_t state_q;

    assign beat_end = running && (state_q == SEQ_BUSY) && xfer_done;

    // Advance the sequencer and drive the registered acknowledge and start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            dack       <= 1'b0;
            xfer_start <= 1'b0;
            xfer_len   <= '0;
        end else begin
            xfer_start <= 1'b0;
            if (!running) begin
                state_q <= SEQ_IDLE;
                dack    <= 1'b0;
            end else begin
                case (state_q)
                    SEQ_IDLE: begin
                        if (req_s && !cnt_zero) begin
                            state_q    <= SEQ_BUSY;
                            dack       <= 1'b1;
                            xfer_start <= 1'b1;
                            xfer_len   <= LEN_W'(beats_for(burst4));
                        end
                    end
                    SEQ_BUSY: begin
                        if (xfer_done) begin
                            if (mode_hs) begin
                                state_q <= SEQ_HOLD;
                            end else begin
                                state_q <= SEQ_IDLE;
                                dack    <= 1'b0;
                            end
                        end
                    end
                    SEQ_HOLD: begin
                        if (!req_s) begin
                            state_q <= SEQ_IDLE;
                            dack    <= 1'b0;
                        end
                    end
                    default: begin
                        state_q <= SEQ_IDLE;
                        dack    <= 1'b0;
                    end
                endcase
            end
        end
    end

    AST_START_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> dack); // R2
    AST_ONE_START_PER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_BUSY && !xfer_done) |=> !xfer_start); // R2
    AST_HS_HOLD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (running && state_q == SEQ_HOLD && req_s) |=> dack); // R3
    AST_DEMAND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_end && !mode_hs) |=> !dack); // R4
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (xfer_len == LEN_W'(UNIT_BEATS) || xfer_len == LEN_W'(BURST_BEATS))); // R5
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (!dack && !xfer_start)); // R9
    AST_ZERO_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_zero |=> !xfer_start); // R11

endmodule

// File: rtl/dma_chan_seq.sv
// Module: top of the DMA channel request sequencer. Ties the request
// synchronizer, the state machine and the transfer counter together and
// detects the enable rise that loads the count.
// Assumes control inputs are quasi-static while the channel is enabled.
module dma_chan_seq #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LEN_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             mode_hs,
    input  logic             burst4,
    input  logic             irq_en,
    input  logic [CNT_W-1:0] init_count,
    input  logic             dreq,
    output logic             dack,
    output logic             xfer_start,
    output logic [LEN_W-1:0] xfer_len,
    input  logic             xfer_done,
    output logic [CNT_W-1:0] cur_count,
    output logic             tc_irq,
    output logic             tc_flag,
    input  logic             tc_clr
);

    logic en_q;
    logic load_cnt;
    logic running;
    logic req_s;
    logic cnt_zero;
    logic beat_end;

    // Remember the previous enable level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= chan_en;
        end
    end

    assign load_cnt = chan_en && !en_q;
    assign running  = chan_en && en_q;

    dma_req_sync #(
        .STAGES  (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(dreq),
        .sync_out(req_s)
    );

    dma_seq_fsm #(
        .LEN_W     (LEN_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (running),
        .req_s     (req_s),
        .cnt_zero  (cnt_zero),
        .mode_hs   (mode_hs),
        .burst4    (burst4),
        .xfer_done (xfer_done),
        .dack      (dack),
        .xfer_start(xfer_start),
        .xfer_len  (xfer_len),
        .beat_end  (beat_end)
    );

    dma_tc_counter #(
        .CNT_W  (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_cnt),
        .init   (init_count),
        .dec    (beat_end),
        .irq_en (irq_en),
        .clr    (tc_clr),
        .count  (cur_count),
        .is_zero(cnt_zero),
        .tc_irq (tc_irq),
        .tc_flag(tc_flag)
    );

    AST_KEEP_COUNT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en && en_q) |=> $stable(cur_count)); // R9

endmodule

// File: tb/sim_dma_chan_seq.sv
module sim_dma_chan_seq;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             chan_en = 1'b0;
    logic             mode_hs = 1'b0;
    logic             burst4 = 1'b0;
    logic             irq_en = 1'b0;
    logic [CNT_W-1:0] init_count = '0;
    logic             dreq = 1'b0;
    logic             dack;
    logic             xfer_start;
    logic [2:0]       xfer_len;
    logic             xfer_done = 1'b0;
    logic [CNT_W-1:0] cur_count;
    logic             tc_irq;
    logic             tc_flag;
    logic             tc_clr = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit cmp_on = 0;
    bit spur_on = 0;
    bit eng_busy = 0;
    int eng_wait = 0;

    // reference model state
    bit m_s1, m_s2, m_en_d, m_dack, m_start, m_irq, m_flag;
    int m_state, m_len, m_cnt;

    always #5 clk = ~clk;

    dma_chan_seq #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .mode_hs(mode_hs),
        .burst4(burst4), .irq_en(irq_en), .init_count(init_count),
        .dreq(dreq), .dack(dack), .xfer_start(xfer_start),
        .xfer_len(xfer_len), .xfer_done(xfer_done), .cur_count(cur_count),
        .tc_irq(tc_irq), .tc_flag(tc_flag), .tc_clr(tc_clr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected behaviour computed from the requirements, one edge at a time.
    always @(posedge clk) begin
        bit old_s2, run, take;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_en_d = 0; m_dack = 0; m_start = 0;
            m_irq = 0; m_flag = 0; m_state = 0; m_len = 0; m_cnt = 0;
        end else begin
            old_s2 = m_s2;
            m_s2 = m_s1;
            m_s1 = dreq;
            run = chan_en && m_en_d;
            take = run && m_state == 1 && xfer_done && m_cnt != 0;
            m_start = 0;
            m_irq = irq_en && take && m_cnt == 1;
            if (take && m_cnt == 1) m_flag = 1;
            else if (tc_clr) m_flag = 0;
            if (!run) begin
                m_state = 0; m_dack = 0;
            end else if (m_state == 0) begin
                if (old_s2 && m_cnt != 0) begin
                    m_state = 1; m_dack = 1; m_start = 1; m_len = burst4 ? 4 : 1;
                end
            end else if (m_state == 1) begin
                if (xfer_done) begin
                    if (mode_hs) m_state = 2;
                    else begin m_state = 0; m_dack = 0; end
                end
            end else begin
                if (!old_s2) begin m_state = 0; m_dack = 0; end
            end
            if (chan_en && !m_en_d) m_cnt = int'(init_count);
            else if (take) m_cnt = m_cnt - 1;
            m_en_d = chan_en;
        end
    end

    // Cycle-by-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(mode_hs ? "R3 dack" : "R4 dack", int'(dack), int'(m_dack));
            chk("R2 start", int'(xfer_start), int'(m_start));
            if (m_start) chk("R5 len", int'(xfer_len), m_len);
            chk("R6 count", int'(cur_count), m_cnt);
            chk("R7 irq", int'(tc_irq), int'(m_irq));
            chk("R8 flag", int'(tc_flag), int'(m_flag));
        end
    end

    // One cycle: wait for the falling edge and run the transfer engine model.
    task automatic step();
        @(negedge clk);
        xfer_done = 1'b0;
        if (eng_busy) begin
            if (eng_wait == 0) begin
                xfer_done = 1'b1;
                eng_busy = 0;
            end else begin
                eng_wait--;
            end
        end else if (spur_on && ($urandom % 30) == 0) begin
            xfer_done = 1'b1;
        end
        if (xfer_start) begin
            eng_busy = 1;
            eng_wait = int'($urandom % (xfer_len + 2));
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_start(input int limit);
        for (int i = 0; i < limit && !xfer_start; i++) step();
    endtask

    task automatic random_phase(input int n);
        for (int i = 0; i < n; i++) begin
            step();
            if (($urandom % 6) == 0) dreq = ~dreq;
            tc_clr = (($urandom % 15) == 0);
            if (($urandom % 70) == 0) begin
                chan_en = ~chan_en;
                if (!chan_en) begin
                    mode_hs = $urandom % 2;
                    burst4 = $urandom % 2;
                    irq_en = $urandom % 2;
                    init_count = CNT_W'($urandom % 7);
                end
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        steps(3);
        // R1: reset state
        chk("R1 dack", int'(dack), 0);
        chk("R1 start", int'(xfer_start), 0);
        chk("R1 irq", int'(tc_irq), 0);
        chk("R1 flag", int'(tc_flag), 0);
        chk("R1 count", int'(cur_count), 0);
        rst_n = 1'b1;
        cmp_on = 1;
        step();
        chk("R1 dack after release", int'(dack), 0);

        // R10: synchronizer latency in handshake mode with a 1-unit burst
        mode_hs = 1; burst4 = 0; irq_en = 1; init_count = 8'd3; chan_en = 1;
        steps(4);
        dreq = 1;
        step(); chk("R10 edge1", int'(dack), 0);
        step(); chk("R10 edge2", int'(dack), 0);
        step(); chk("R10 edge3", int'(dack), 1);
        // R3: hold acknowledge while request stays high after done
        steps(12);
        chk("R3 hold", int'(dack), 1);
        chk("R6 one step", int'(cur_count), 2);
        dreq = 0;
        step(); step();
        chk("R3 still held", int'(dack), 1);
        step();
        chk("R3 released", int'(dack), 0);

        // R4: demand mode, request held high, repeated bursts of four
        chan_en = 0; step();
        mode_hs = 0; burst4 = 1; irq_en = 1; init_count = 8'd2; chan_en = 1;
        dreq = 1;
        wait_start(20);
        chk("R5 burst len", int'(xfer_len), 4);
        wait_start(30);
        if (!xfer_start) step();
        steps(1);
        wait_start(30);
        chk("R4 second start", int'(xfer_start) | int'(cur_count == 0), 1);
        steps(30);
        chk("R11 count zero", int'(cur_count), 0);
        chk("R8 flag set", int'(tc_flag), 1);
        // R11: no transfer while count is zero
        for (int i = 0; i < 10; i++) begin
            step();
            chk("R11 no start", int'(xfer_start), 0);
        end
        tc_clr = 1; step(); tc_clr = 0; step();
        chk("R8 cleared", int'(tc_flag), 0);

        // R7: interrupt disabled, flag still set
        chan_en = 0; dreq = 0; step();
        irq_en = 0; init_count = 8'd1; chan_en = 1; dreq = 1;
        for (int i = 0; i < 30; i++) begin
            step();
            chk("R7 no irq", int'(tc_irq), 0);
        end
        chk("R8 flag without irq", int'(tc_flag), 1);

        // R9: disable during a transfer keeps the count
        chan_en = 0; dreq = 0; step();
        mode_hs = 1; init_count = 8'd5; chan_en = 1; dreq = 1;
        wait_start(20);
        step();
        chan_en = 0;
        step();
        chk("R9 dack low", int'(dack), 0);
        chk("R9 count kept", int'(cur_count), 5);
        steps(5);

        // randomized phases with spurious done pulses (R6)
        spur_on = 1;
        random_phase(20000);
        spur_on = 0;
        random_phase(5000);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule